// File: doc/BRIEF.md
# Ring-Based Request List Controller

This block sits on the device side of a host link. It moves requests through two circular lists that both live in its own storage. The host fills inbound units through a register window; each unit holds a request address and a request size. The host then writes the index of the last unit it filled into the write-pointer register. The controller walks its own read index forward, one unit per cycle, until it reaches that pointer. It hands each unit to the processor side over a valid/ready port and stalls whenever the processor side is not ready.

When the processor side reports a finished request, the controller ORs the completion flag word with a fixed host-bits mask and stores the result in the next outbound unit. That unit's index becomes visible as the shadow copy pointer, and the completion cause bit is raised. The host compares the shadow with its own saved read index N; if the two differ, it reads unit N+1, wrapping at the count. Two side channels are also provided. The first is a message pair for non-queued commands: the host writes a command word, and completion is flagged when the processor writes back the same word. The second is a doorbell from the processor to the host, with a per-bit enable.

Top module: `ring_list_ctrl`

## Requirements
- R1: After reset the count is MAX_UNITS, the read index, write pointer and shadow are all MAX_UNITS-1, every cause, enable, message and doorbell register is zero, no request is offered and no interrupt is raised.
- R2: A request is offered while the read index differs from the write pointer. The unit offered is the read index plus one, wrapping to 0 at the count. Each accepted handshake advances the read index by one unit.
- R3: While a request is offered and req_ready is low, the offered index, address and size hold unchanged.
- R4: The inbound address register (window 0x40+i) stores bits 31:5 only. The address read back and the address offered as req_addr have bits 4:0 at zero. The size register (window 0x80+i) holds 16 bits.
- R5: An accepted completion stores cpl_flag OR 0x4000_0000 into the unit after the shadow (with wrap). The shadow (register 0x02) moves to that unit in the same edge, and cause bit 0 (register 0x03) is set. The outbound unit is read at window 0xC0+i.
- R6: After count completions without an acknowledge, cpl_ready is low. Writing 1 to cause bit 0 acknowledges every stored completion and frees the whole list.
- R7: list_irq is high exactly when the function enable (register 0x05 bit 0) is set and some cause bit is set together with its enable bit in register 0x04.
- R8: Cause bits are write-1-to-clear. A set event in the same cycle as the clear wins, and an acknowledge that meets an accepted completion leaves exactly that one completion outstanding.
- R9: A host write to register 0x06 appears on cpu_msg one cycle later, with cpu_msg_new high for that one cycle. A processor write on cpu_msg_we stores the word in register 0x07, and it sets cause bit 1 only when the word equals the current 0x06 value.
- R10: cpu_db_set bits set the doorbell (register 0x08). Host writes of 1 clear bits there, and a set wins over a clear. db_irq is the function enable ANDed with any doorbell bit that is enabled in register 0x09.
- R11: A write to register 0x00 (bits 7:0) loads the count, where 0 or any value above MAX_UNITS means MAX_UNITS. The write puts all three indices at count-1, clears pending completions and cause bit 0, and blocks req_valid and cpl_ready in that cycle.
- R12: Ring window writes at an index at or beyond MAX_UNITS are ignored and do not alias onto another unit. Reads there, and reads of unused register offsets, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host word address (bits 7:6 select the window) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| req_valid | output | 1 | A request unit is offered |
| req_ready | input | 1 | Processor side accepts the offered unit |
| req_addr | output | 32 | Offered request address, 32-byte aligned |
| req_size | output | 16 | Offered request size |
| req_idx | output | IDX_W | Index of the offered unit |
| cpl_valid | input | 1 | Processor side presents a completion |
| cpl_ready | output | 1 | Completion can be stored this cycle |
| cpl_flag | input | 32 | Completion flag word |
| cpu_msg | output | 32 | Last host command word |
| cpu_msg_new | output | 1 | One-cycle pulse after a new command word |
| cpu_msg_we | input | 1 | Processor writes its reply word |
| cpu_msg_wdata | input | 32 | Processor reply word |
| cpu_db_set | input | DB_W | Doorbell bits to set |
| list_irq | output | 1 | List and message interrupt |
| db_irq | output | 1 | Doorbell interrupt |

## Verification
The bench builds the block with MAX_UNITS set to 16 and DB_W set to 4. With 16 as the ceiling, the bench can try count values of zero and above the ceiling and show that they clamp. It can also write at window index 20, which lies outside the ring but would alias onto unit 4 if the upper index bits were dropped. A count of 5 lets both indices wrap within a few requests, and the outbound list fills after five completions, so the backpressure and the acknowledge path are both exercised in a short run.

// File: rtl/rl_pkg.sv
package rl_pkg;

    localparam logic [31:0] HOST_BITS = 32'h4000_0000;

    typedef enum logic [7:0] {
        REG_CFG     = 8'h00,
        REG_WPTR    = 8'h01,
        REG_SHADOW  = 8'h02,
        REG_CAUSE   = 8'h03,
        REG_ENABLE  = 8'h04,
        REG_FUNC_EN = 8'h05,
        REG_MSG_IN  = 8'h06,
        REG_MSG_OUT = 8'h07,
        REG_BELL    = 8'h08,
        REG_BELL_EN = 8'h09
    } reg_e;

    localparam logic [1:0] WIN_REGS    = 2'd0;
    localparam logic [1:0] WIN_IN_ADDR = 2'd1;
    localparam logic [1:0] WIN_IN_SIZE = 2'd2;
    localparam logic [1:0] WIN_OUT     = 2'd3;

    typedef struct packed {
        logic [26:0] line;
        logic [15:0] size;
    } in_unit_t;

    function automatic logic [7:0] ring_next(input logic [7:0] idx, input logic [7:0] cnt);
        return (idx + 8'd1 >= cnt) ? 8'd0 : idx + 8'd1;
    endfunction

    function automatic logic [7:0] clamp_count(input logic [7:0] v, input int max_units);
        return (v == 8'd0 || int'(v) > max_units) ? 8'(max_units) : v;
    endfunction

endpackage

// File: rtl/rl_inbound.sv
module rl_inbound import rl_pkg::*; #(
    parameter int MAX_UNITS = 64,
    parameter int IDX_W     = $clog2(MAX_UNITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [IDX_W-1:0] reload_idx,
    input  logic [7:0]       cnt,
    input  logic             block,
    input  logic             wp_we,
    input  logic [IDX_W-1:0] wp_data,
    input  logic             line_we,
    input  logic             size_we,
    input  logic [IDX_W-1:0] unit_sel,
    input  logic [26:0]      unit_line,
    input  logic [15:0]      unit_size,
    input  logic [IDX_W-1:0] look_sel,
    output logic [31:0]      look_addr,
    output logic [15:0]      look_size,
    output logic [IDX_W-1:0] wp_q,
    output logic [IDX_W-1:0] rd_q,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [31:0]      req_addr,
    output logic [15:0]      req_size,
    output logic [IDX_W-1:0] req_idx
);
    in_unit_t         units [MAX_UNITS];
    logic [IDX_W-1:0] nxt;

    assign nxt       = IDX_W'(ring_next(8'(rd_q), cnt));
    assign req_valid = !block && (rd_q != wp_q);
    assign req_idx   = nxt;
    assign req_addr  = {units[nxt].line, 5'd0};
    assign req_size  = units[nxt].size;
    assign look_addr = {units[look_sel].line, 5'd0};
    assign look_size = units[look_sel].size;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= IDX_W'(MAX_UNITS - 1);
            wp_q <= IDX_W'(MAX_UNITS - 1);
            for (int i = 0; i < MAX_UNITS; i++) units[i] <= '0;
        end else begin
            if (reload) begin
                rd_q <= reload_idx;
                wp_q <= reload_idx;
            end else begin
                if (wp_we) wp_q <= wp_data;
                if (req_valid && req_ready) rd_q <= nxt;
            end
            if (line_we) units[unit_sel].line <= unit_line;
            if (size_we) units[unit_sel].size <= unit_size;
        end
    end
endmodule

// File: rtl/rl_outbound.sv
module rl_outbound import rl_pkg::*; #(
    parameter int MAX_UNITS = 64,
    parameter int IDX_W     = $clog2(MAX_UNITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [IDX_W-1:0] reload_idx,
    input  logic [7:0]       cnt,
    input  logic             block,
    input  logic             cpl_valid,
    input  logic [31:0]      cpl_flag,
    output logic             cpl_ready,
    input  logic             ack,
    output logic             done_q,
    output logic [IDX_W-1:0] shadow_q,
    input  logic [IDX_W-1:0] look_sel,
    output logic [31:0]      look_word
);
    logic [31:0]      ring [MAX_UNITS];
    logic [7:0]       pending_q;
    logic [IDX_W-1:0] nxt;
    logic             take;

    assign nxt       = IDX_W'(ring_next(8'(shadow_q), cnt));
    assign cpl_ready = !block && (pending_q < cnt);
    assign take      = cpl_valid && cpl_ready;
    assign look_word = ring[look_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q  <= IDX_W'(MAX_UNITS - 1);
            pending_q <= '0;
            done_q    <= 1'b0;
            for (int i = 0; i < MAX_UNITS; i++) ring[i] <= '0;
        end else if (reload) begin
            shadow_q  <= reload_idx;
            pending_q <= '0;
            done_q    <= 1'b0;
        end else if (take) begin
            ring[nxt] <= cpl_flag | HOST_BITS;
            shadow_q  <= nxt;
            pending_q <= ack ? 8'd1 : pending_q + 8'd1;
            done_q    <= 1'b1;
        end else if (ack) begin
            pending_q <= '0;
            done_q    <= 1'b0;
        end
    end
endmodule

// File: rtl/rl_mailbox.sv
module rl_mailbox #(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            msg_we,
    input  logic            bell_clr_we,
    input  logic [31:0]     wdata,
    input  logic            ack,
    input  logic            cpu_msg_we,
    input  logic [31:0]     cpu_msg_wdata,
    input  logic [DB_W-1:0] cpu_db_set,
    output logic [31:0]     msg_in_q,
    output logic [31:0]     msg_out_q,
    output logic            msg_new_q,
    output logic            hit_q,
    output logic [DB_W-1:0] bell_q
);
    logic [DB_W-1:0] clr_mask;
    assign clr_mask = bell_clr_we ? wdata[DB_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_in_q  <= '0;
            msg_out_q <= '0;
            msg_new_q <= 1'b0;
            hit_q     <= 1'b0;
            bell_q    <= '0;
        end else begin
            msg_new_q <= msg_we;
            if (msg_we) msg_in_q <= wdata;
            if (cpu_msg_we) msg_out_q <= cpu_msg_wdata;
            if (cpu_msg_we && cpu_msg_wdata == msg_in_q) hit_q <= 1'b1;
            else if (ack) hit_q <= 1'b0;
            bell_q <= (bell_q & ~clr_mask) | cpu_db_set;
        end
    end
endmodule

// File: rtl/ring_list_ctrl.sv
module ring_list_ctrl import rl_pkg::*; #(
    parameter int MAX_UNITS = 64,
    parameter int DB_W      = 8,
    localparam int IDX_W    = $clog2(MAX_UNITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic [7:0]       host_addr,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [31:0]      req_addr,
    output logic [15:0]      req_size,
    output logic [IDX_W-1:0] req_idx,
    input  logic             cpl_valid,
    output logic             cpl_ready,
    input  logic [31:0]      cpl_flag,
    output logic [31:0]      cpu_msg,
    output logic             cpu_msg_new,
    input  logic             cpu_msg_we,
    input  logic [31:0]      cpu_msg_wdata,
    input  logic [DB_W-1:0]  cpu_db_set,
    output logic             list_irq,
    output logic             db_irq
);
    logic [1:0]       win;
    logic [5:0]       off;
    logic             in_range;
    logic [IDX_W-1:0] sel;
    logic             cfg_wr;
    logic [7:0]       new_cnt;
    logic [IDX_W-1:0] new_last;
    logic [7:0]       cnt_q;
    logic [1:0]       en_q;
    logic             fen_q;
    logic [DB_W-1:0]  bell_en_q;
    logic [1:0]       cause;
    logic             done_q, hit_q;
    logic [IDX_W-1:0] wp_q, rd_idx, shadow_idx;
    logic [31:0]      in_addr_rd, out_rd, msg_out_q;
    logic [15:0]      in_size_rd;
    logic [DB_W-1:0]  bell_q;

    assign win      = host_addr[7:6];
    assign off      = host_addr[5:0];
    assign in_range = ({26'd0, off} < 32'(MAX_UNITS));
    assign sel      = IDX_W'(off);
    assign cfg_wr   = host_we && (host_addr == REG_CFG);
    assign new_cnt  = clamp_count(host_wdata[7:0], MAX_UNITS);
    assign new_last = IDX_W'(new_cnt - 8'd1);
    assign cause    = {hit_q, done_q};

    rl_inbound #(.MAX_UNITS(MAX_UNITS), .IDX_W(IDX_W)) u_in (
        .clk(clk), .rst(rst), .reload(cfg_wr), .reload_idx(new_last), .cnt(cnt_q),
        .block(cfg_wr), .wp_we(host_we && host_addr == REG_WPTR),
        .wp_data(IDX_W'(host_wdata)),
        .line_we(host_we && win == WIN_IN_ADDR && in_range),
        .size_we(host_we && win == WIN_IN_SIZE && in_range),
        .unit_sel(sel), .unit_line(host_wdata[31:5]), .unit_size(host_wdata[15:0]),
        .look_sel(sel), .look_addr(in_addr_rd), .look_size(in_size_rd),
        .wp_q(wp_q), .rd_q(rd_idx), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_idx(req_idx)
    );

    rl_outbound #(.MAX_UNITS(MAX_UNITS), .IDX_W(IDX_W)) u_out (
        .clk(clk), .rst(rst), .reload(cfg_wr), .reload_idx(new_last), .cnt(cnt_q),
        .block(cfg_wr), .cpl_valid(cpl_valid), .cpl_flag(cpl_flag), .cpl_ready(cpl_ready),
        .ack(host_we && host_addr == REG_CAUSE && host_wdata[0]),
        .done_q(done_q), .shadow_q(shadow_idx), .look_sel(sel), .look_word(out_rd)
    );

    rl_mailbox #(.DB_W(DB_W)) u_mbox (
        .clk(clk), .rst(rst), .msg_we(host_we && host_addr == REG_MSG_IN),
        .bell_clr_we(host_we && host_addr == REG_BELL), .wdata(host_wdata),
        .ack(host_we && host_addr == REG_CAUSE && host_wdata[1]),
        .cpu_msg_we(cpu_msg_we), .cpu_msg_wdata(cpu_msg_wdata), .cpu_db_set(cpu_db_set),
        .msg_in_q(cpu_msg), .msg_out_q(msg_out_q), .msg_new_q(cpu_msg_new),
        .hit_q(hit_q), .bell_q(bell_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= 8'(MAX_UNITS);
            en_q      <= '0;
            fen_q     <= 1'b0;
            bell_en_q <= '0;
        end else if (host_we) begin
            if (host_addr == REG_CFG)     cnt_q     <= new_cnt;
            if (host_addr == REG_ENABLE)  en_q      <= host_wdata[1:0];
            if (host_addr == REG_FUNC_EN) fen_q     <= host_wdata[0];
            if (host_addr == REG_BELL_EN) bell_en_q <= host_wdata[DB_W-1:0];
        end
    end

    assign list_irq = fen_q && |(cause & en_q);
    assign db_irq   = fen_q && |(bell_q & bell_en_q);

    always_comb begin
        host_rdata = '0;
        case (win)
            WIN_REGS: begin
                case (host_addr)
                    REG_CFG:     host_rdata = 32'(cnt_q);
                    REG_WPTR:    host_rdata = 32'(wp_q);
                    REG_SHADOW:  host_rdata = 32'(shadow_idx);
                    REG_CAUSE:   host_rdata = 32'(cause);
                    REG_ENABLE:  host_rdata = 32'(en_q);
                    REG_FUNC_EN: host_rdata = 32'(fen_q);
                    REG_MSG_IN:  host_rdata = cpu_msg;
                    REG_MSG_OUT: host_rdata = msg_out_q;
                    REG_BELL:    host_rdata = 32'(bell_q);
                    REG_BELL_EN: host_rdata = 32'(bell_en_q);
                    default:     host_rdata = '0;
                endcase
            end
            WIN_IN_ADDR: if (in_range) host_rdata = in_addr_rd;
            WIN_IN_SIZE: if (in_range) host_rdata = 32'(in_size_rd);
            default:     if (in_range) host_rdata = out_rd;
        endcase
    end
endmodule

// File: rtl/ring_list_chk.sv
module ring_list_chk #(
    parameter int IDX_W = 6,
    parameter int DB_W  = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             host_we,
    input logic [7:0]       host_addr,
    input logic [31:0]      host_wdata,
    input logic             req_valid,
    input logic             req_ready,
    input logic [IDX_W-1:0] req_idx,
    input logic             cpl_valid,
    input logic             cpl_ready,
    input logic             cpu_msg_new,
    input logic [DB_W-1:0]  cpu_db_set,
    input logic             list_irq,
    input logic [IDX_W-1:0] rd_idx,
    input logic [IDX_W-1:0] shadow_idx,
    input logic             done_q,
    input logic [DB_W-1:0]  bell_q
);
    logic cfg_wr;
    assign cfg_wr = host_we && host_addr == 8'h00;

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!req_valid && !list_irq));

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(req_valid && req_ready) && !cfg_wr) |=> $stable(rd_idx));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !cfg_wr) |=> $stable(req_idx));

    // R5
    cause_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && cpl_ready) |=> done_q);

    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(cpl_valid && cpl_ready) && !cfg_wr) |=> $stable(shadow_idx));

    // R9
    msg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_msg_new |-> $past(host_we && host_addr == 8'h06));

    // R10
    bell_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == 8'h08 && host_wdata[DB_W-1:0] == '1 && cpu_db_set == '0)
        |=> (bell_q == '0));
endmodule

bind ring_list_ctrl ring_list_chk #(.IDX_W(IDX_W), .DB_W(DB_W)) u_chk (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpu_msg_new(cpu_msg_new), .cpu_db_set(cpu_db_set), .list_irq(list_irq),
    .rd_idx(rd_idx), .shadow_idx(shadow_idx), .done_q(done_q), .bell_q(bell_q)
);

// File: tb/sim_ring_list_ctrl.sv
module sim_ring_list_ctrl;
    localparam int CLK_NS = 10;
    localparam int MAXU   = 16;
    localparam int DBW    = 4;
    localparam int IW     = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_we = 1'b0;
    logic [7:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic req_valid, req_ready = 1'b0;
    logic [31:0] req_addr;
    logic [15:0] req_size;
    logic [IW-1:0] req_idx;
    logic cpl_valid = 1'b0, cpl_ready;
    logic [31:0] cpl_flag = '0;
    logic [31:0] cpu_msg;
    logic cpu_msg_new;
    logic cpu_msg_we = 1'b0;
    logic [31:0] cpu_msg_wdata = '0;
    logic [DBW-1:0] cpu_db_set = '0;
    logic list_irq, db_irq;

    always #(CLK_NS/2) clk = ~clk;

    ring_list_ctrl #(.MAX_UNITS(MAXU), .DB_W(DBW)) u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_size(req_size), .req_idx(req_idx),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_flag(cpl_flag),
        .cpu_msg(cpu_msg), .cpu_msg_new(cpu_msg_new), .cpu_msg_we(cpu_msg_we),
        .cpu_msg_wdata(cpu_msg_wdata), .cpu_db_set(cpu_db_set),
        .list_irq(list_irq), .db_irq(db_irq)
    );

    int checks = 0;
    int failures = 0;
    string cur_tag = "R1";

    // behavioural reference state
    int m_cnt, m_rd, m_wp, m_sh, m_pend;
    logic [31:0] m_in_addr [MAXU];
    logic [15:0] m_in_size [MAXU];
    logic [31:0] m_out [MAXU];
    logic [1:0] m_cause, m_en;
    logic m_fen, m_new;
    logic [31:0] m_msg_in, m_msg_out;
    logic [DBW-1:0] m_bell, m_bell_en;

    function automatic int nx(int i);
        return (i + 1 >= m_cnt) ? 0 : i + 1;
    endfunction

    task automatic model_reset();
        m_cnt = MAXU; m_rd = MAXU-1; m_wp = MAXU-1; m_sh = MAXU-1; m_pend = 0;
        for (int i = 0; i < MAXU; i++) begin
            m_in_addr[i] = '0; m_in_size[i] = '0; m_out[i] = '0;
        end
        m_cause = '0; m_en = '0; m_fen = 0; m_new = 0;
        m_msg_in = '0; m_msg_out = '0; m_bell = '0; m_bell_en = '0;
    endtask

    function automatic logic blocked();
        return host_we && host_addr == 8'h00;
    endfunction

    function automatic logic [31:0] exp_rdata();
        int off;
        off = int'(host_addr[5:0]);
        case (host_addr[7:6])
            2'd0: case (off)
                0: return 32'(m_cnt);
                1: return 32'(m_wp);
                2: return 32'(m_sh);
                3: return 32'(m_cause);
                4: return 32'(m_en);
                5: return 32'(m_fen);
                6: return m_msg_in;
                7: return m_msg_out;
                8: return 32'(m_bell);
                9: return 32'(m_bell_en);
                default: return '0;
            endcase
            2'd1: return (off < MAXU) ? m_in_addr[off] : '0;
            2'd2: return (off < MAXU) ? 32'(m_in_size[off]) : '0;
            default: return (off < MAXU) ? m_out[off] : '0;
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic ev;
        ev = !blocked() && (m_rd != m_wp);
        chk("R2", "req_valid", 32'(req_valid), 32'(ev));
        if (ev) begin
            chk("R2", "req_idx", 32'(req_idx), 32'(nx(m_rd)));
            chk("R4", "req_addr", req_addr, m_in_addr[nx(m_rd)]);
            chk("R2", "req_size", 32'(req_size), 32'(m_in_size[nx(m_rd)]));
        end
        chk("R6", "cpl_ready", 32'(cpl_ready), 32'(!blocked() && m_pend < m_cnt));
        chk("R7", "list_irq", 32'(list_irq), 32'(m_fen && |(m_cause & m_en)));
        chk("R10", "db_irq", 32'(db_irq), 32'(m_fen && |(m_bell & m_bell_en)));
        chk("R9", "cpu_msg", cpu_msg, m_msg_in);
        chk("R9", "cpu_msg_new", 32'(cpu_msg_new), 32'(m_new));
        chk(cur_tag, "host_rdata", host_rdata, exp_rdata());
    endtask

    task automatic model_step();
        logic hs_req, hs_cpl, ack0, ack1, hit;
        int off;
        logic [DBW-1:0] clr;
        off = int'(host_addr[5:0]);
        hs_req = !blocked() && (m_rd != m_wp) && req_ready;
        hs_cpl = !blocked() && (m_pend < m_cnt) && cpl_valid;
        ack0 = host_we && host_addr == 8'h03 && host_wdata[0];
        ack1 = host_we && host_addr == 8'h03 && host_wdata[1];
        hit = cpu_msg_we && cpu_msg_wdata == m_msg_in;
        clr = (host_we && host_addr == 8'h08) ? host_wdata[DBW-1:0] : '0;
        if (hs_req) m_rd = nx(m_rd);
        if (hs_cpl) begin
            m_out[nx(m_sh)] = cpl_flag | 32'h4000_0000;
            m_sh = nx(m_sh);
            m_pend = ack0 ? 1 : m_pend + 1;
            m_cause[0] = 1'b1;
        end else if (ack0) begin
            m_pend = 0; m_cause[0] = 1'b0;
        end
        if (hit) m_cause[1] = 1'b1;
        else if (ack1) m_cause[1] = 1'b0;
        if (cpu_msg_we) m_msg_out = cpu_msg_wdata;
        m_bell = (m_bell & ~clr) | cpu_db_set;
        m_new = host_we && host_addr == 8'h06;
        if (host_we) begin
            case (host_addr[7:6])
                2'd0: case (off)
                    0: begin
                        m_cnt = int'(host_wdata[7:0]);
                        if (m_cnt == 0 || m_cnt > MAXU) m_cnt = MAXU;
                        m_rd = m_cnt - 1; m_wp = m_cnt - 1; m_sh = m_cnt - 1;
                        m_pend = 0; m_cause[0] = 1'b0;
                    end
                    1: m_wp = int'(host_wdata[IW-1:0]);
                    4: m_en = host_wdata[1:0];
                    5: m_fen = host_wdata[0];
                    6: m_msg_in = host_wdata;
                    9: m_bell_en = host_wdata[DBW-1:0];
                    default: ;
                endcase
                2'd1: if (off < MAXU) m_in_addr[off] = host_wdata & ~32'h1F;
                2'd2: if (off < MAXU) m_in_size[off] = host_wdata[15:0];
                default: ;
            endcase
        end
    endtask

    // called at a negative edge with inputs already set; returns at the next one
    task automatic tick();
        #2;
        if (!rst) compare();
        @(posedge clk);
        if (rst) model_reset(); else model_step();
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        tick();
        host_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a);
        host_addr = a;
        tick();
    endtask

    initial begin
        #(CLK_NS * 20000);
        failures++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        idle(2);
        rst = 1'b0;

        cur_tag = "R1";
        for (int a = 0; a < 10; a++) rd(8'(a));

        cur_tag = "R11";
        wr(8'h00, 32'd0); rd(8'h00);
        wr(8'h00, 32'd200); rd(8'h00);
        wr(8'h00, 32'd5); rd(8'h00); rd(8'h01); rd(8'h02);

        cur_tag = "R4";
        for (int i = 0; i < 5; i++) begin
            wr(8'h40 + 8'(i), 32'h1000_0000 + 32'(i * 64) + 32'h1F);
            wr(8'h80 + 8'(i), 32'hABC0_0000 + 32'(i + 1));
        end
        rd(8'h42); rd(8'h83);

        cur_tag = "R2";
        wr(8'h01, 32'd2);
        req_ready = 1'b1; idle(5);

        cur_tag = "R3";
        req_ready = 1'b0;
        wr(8'h01, 32'd1);
        idle(3);
        req_ready = 1'b1; idle(6);

        cur_tag = "R11";
        req_ready = 1'b0; wr(8'h01, 32'd3); cpl_valid = 1'b1; cpl_flag = 32'h77;
        wr(8'h00, 32'd5);
        cpl_valid = 1'b0; rd(8'h01); rd(8'h02);

        cur_tag = "R5";
        wr(8'h04, 32'd1); wr(8'h05, 32'd1);
        cpl_valid = 1'b1;
        for (int i = 0; i < 7; i++) begin
            cpl_flag = 32'h100 + 32'(i);
            tick();
        end
        cur_tag = "R6";
        rd(8'h02);
        wr(8'h03, 32'd1);
        cpl_flag = 32'h200; tick();
        cpl_valid = 1'b0;
        cur_tag = "R5";
        for (int i = 0; i < 5; i++) rd(8'hC0 + 8'(i));
        rd(8'h02); rd(8'h03);

        cur_tag = "R8";
        cpl_valid = 1'b1; cpl_flag = 32'h300;
        wr(8'h03, 32'd1);
        cpl_valid = 1'b0; rd(8'h03);
        wr(8'h03, 32'd1); rd(8'h03);
        cpl_valid = 1'b1; cpl_flag = 32'h301; tick(); cpl_valid = 1'b0;

        cur_tag = "R7";
        wr(8'h05, 32'd0); idle(2);
        wr(8'h05, 32'd1); wr(8'h04, 32'd0); idle(2);

        cur_tag = "R9";
        wr(8'h04, 32'd2);
        wr(8'h06, 32'hABCD_0001); idle(2);
        cpu_msg_we = 1'b1; cpu_msg_wdata = 32'h1234_5678; tick();
        cpu_msg_we = 1'b0; rd(8'h07); rd(8'h03);
        cpu_msg_we = 1'b1; cpu_msg_wdata = 32'hABCD_0001; tick();
        cpu_msg_we = 1'b0; rd(8'h03); rd(8'h07);
        wr(8'h03, 32'd2); rd(8'h03);

        cur_tag = "R10";
        cpu_db_set = 4'b0101; tick(); cpu_db_set = '0;
        rd(8'h08);
        wr(8'h09, 32'h4); idle(1);
        wr(8'h08, 32'h4); rd(8'h08);
        cpu_db_set = 4'b0001; wr(8'h08, 32'h1); cpu_db_set = '0; rd(8'h08);
        wr(8'h08, 32'hF); rd(8'h08);

        cur_tag = "R12";
        wr(8'h40 + 8'd20, 32'hDEAD_BEE0); rd(8'h40 + 8'd20); rd(8'h44);
        wr(8'h80 + 8'd17, 32'h55); rd(8'h81);
        rd(8'hC0 + 8'd30); rd(8'h0C); rd(8'h3F);

        cur_tag = "R2";
        wr(8'h00, 32'd16);
        for (int i = 0; i < 16; i++) wr(8'h40 + 8'(i), 32'(i) << 8);
        wr(8'h01, 32'd15);
        req_ready = 1'b1; idle(18);
        req_ready = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule